// File: doc/BRIEF.md
# Parallel Byte-Wide EEPROM Array

This block models a byte-wide electrically erasable memory behind a parallel, strobe-driven interface, for use inside a larger design that needs a nonvolatile-style store with realistic write timing. It holds 512 bytes by default, selected by a 9-bit address. Three active-low controls gate it: a chip select, an output gate and a write request. The data bus is split into an input byte, an output byte and an output-drive qualifier.

All pins are treated as asynchronous to the system clock. Each passes through a two-flop synchronizer before the logic acts on it. A write happens when the host holds the write request low, presents address and data, and pulses the chip select low and then high again. The rising edge of the chip select, seen in the clock domain, captures the address and data and starts an internal programming interval whose length is a clock-count parameter. While that interval runs, the busy flag is high, further strobes are discarded, and reads return the previous contents. The new byte becomes visible when the interval ends.

A read drives the output only when the chip select and the output gate are both low and the write request is high. Whenever the output is not driven, the output byte is held at zero.

Top module: `eep_parallel_store`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy_o` is 0, `dout_oe_o` is 0 and `dout_o` is 0.
- R2: `dout_oe_o` is 1 only when the synchronized chip select is 0, the synchronized output gate is 0 and the synchronized write request is 1. Whenever `dout_oe_o` is 0, `dout_o` is all zeros.
- R3: While the output is driven, `dout_o` equals the byte stored at the synchronized address. It reflects pin changes made before clock edge N from edge N+1 onward, where N+1 is the second edge.
- R4: A write is accepted when the synchronized chip select goes from 0 to 1 while the synchronized write request is 0. `busy_o` rises on the third rising clock edge after the chip select pin goes high.
- R5: After an accepted write, `busy_o` stays high for exactly PROG_CYCLES clock cycles. The captured byte is stored at the captured address on the edge where `busy_o` falls.
- R6: While `busy_o` is high, a read of the location being programmed returns the value it held before the write.
- R7: A chip-select strobe that arrives while `busy_o` is high is ignored: it changes no location and does not extend or restart the busy interval.
- R8: A chip-select rising edge while the write request is high does not start programming and changes no location.
- R9: The lowest address (0x000) and the highest address (0x1FF) are distinct locations, and writing one leaves the other unchanged.
- R10: After reset every location reads as the erased value 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 9 | Byte address pins |
| din_i | input | 8 | Data presented for a write |
| ce_n_i | input | 1 | Chip select, active low; its rising edge is the write strobe |
| oe_n_i | input | 1 | Output gate, active low |
| we_n_i | input | 1 | Write request, active low |
| dout_o | output | 8 | Read data; zero when not driven |
| dout_oe_o | output | 1 | High when the block drives the data bus |
| busy_o | output | 1 | High while a byte is being programmed |

## Verification
Every pin change reaches the read path after two clock edges. A write strobe raises busy on the third edge after the chip select pin rises. The programmed byte appears PROG_CYCLES edges after busy rises. The bench drives pins on falling edges and samples on the following falling edges. It therefore reads read data after the second edge following a change, and checks that busy is still low after the second edge and high after the third. A behavioural model delays each pin sample through a queue that is as deep as the synchronizer. It keeps a counter for the programming interval and is compared with `dout_o`, `dout_oe_o` and `busy_o` on every falling edge.

// File: rtl/eep_pkg.sv
package eep_pkg;

   // Phase of the internal programming sequencer
   typedef enum logic [0:0] {
      PH_IDLE = 1'b0,
      PH_PROG = 1'b1
   } prog_phase_e;

   // Number of control pins carried through the synchronizer
   localparam int unsigned CTRL_PINS = 3;

   // Smallest synchronizer depth that is still safe
   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
   parameter int unsigned  WIDTH   = 8,
   parameter int unsigned  STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/eep_write_ctl.sv
module eep_write_ctl
   import eep_pkg::*;
#(
   parameter int unsigned ADDR_W      = 9,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PROG_CYCLES = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n_s,
   input  logic              we_n_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [DATA_W-1:0] din_s,
   output logic              busy_o,
   output logic              commit_o,
   output logic [ADDR_W-1:0] commit_addr_o,
   output logic [DATA_W-1:0] commit_data_o
);

   localparam int unsigned CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

   prog_phase_e       phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              ce_prev_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [DATA_W-1:0] pend_data_q;
   logic              strobe;
   logic              last_cycle;

   // Rising chip select while the write request is held low
   assign strobe     = ce_n_s & ~ce_prev_q & ~we_n_s;
   assign last_cycle = (phase_q == PH_PROG) && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_prev_q <= 1'b1;
      else        ce_prev_q <= ce_n_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         cnt_q       <= '0;
         pend_addr_q <= '0;
         pend_data_q <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (strobe) begin
                  phase_q     <= PH_PROG;
                  cnt_q       <= CNT_LOAD;
                  pend_addr_q <= addr_s;
                  pend_data_q <= din_s;
               end
            end
            PH_PROG: begin
               if (cnt_q == '0) phase_q <= PH_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy_o        = (phase_q == PH_PROG);
   assign commit_o      = last_cycle;
   assign commit_addr_o = pend_addr_q;
   assign commit_data_o = pend_data_q;

endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array #(
   parameter int unsigned      ADDR_W       = 9,
   parameter int unsigned      DATA_W       = 8,
   parameter logic [DATA_W-1:0] ERASED_VALUE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] word_q [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q[w] <= ERASED_VALUE;
         else if (wr_en_i && (wr_addr_i == ADDR_W'(w)))
            word_q[w] <= wr_data_i;
      end
   end

   assign rd_data_o = word_q[rd_addr_i];

endmodule

// File: rtl/eep_parallel_store.sv
module eep_parallel_store
   import eep_pkg::*;
#(
   parameter int unsigned       ADDR_W       = 9,
   parameter int unsigned       DATA_W       = 8,
   parameter int unsigned       SYNC_STAGES  = 2,
   parameter int unsigned       PROG_CYCLES  = 500000,
   parameter logic [DATA_W-1:0] ERASED_VALUE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] din_i,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic              we_n_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              dout_oe_o,
   output logic              busy_o
);

   localparam int unsigned PIN_W = CTRL_PINS + ADDR_W + DATA_W;
   localparam logic [PIN_W-1:0] PIN_IDLE = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

   // Elaboration-time parameter checks
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("eep_parallel_store: ADDR_W must be 1..12");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("eep_parallel_store: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("eep_parallel_store: SYNC_STAGES below safe minimum");
   end
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("eep_parallel_store: PROG_CYCLES must be at least 1");
   end

   logic [PIN_W-1:0]  pins_raw;
   logic [PIN_W-1:0]  pins_s;
   logic              ce_n_s;
   logic              oe_n_s;
   logic              we_n_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] din_s;
   logic              commit;
   logic [ADDR_W-1:0] commit_addr;
   logic [DATA_W-1:0] commit_data;
   logic [DATA_W-1:0] rd_data;
   logic              drive;

   assign pins_raw = {ce_n_i, oe_n_i, we_n_i, addr_i, din_i};

   eep_sync #(
      .WIDTH   (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   assign ce_n_s = pins_s[PIN_W-1];
   assign oe_n_s = pins_s[PIN_W-2];
   assign we_n_s = pins_s[PIN_W-3];
   assign addr_s = pins_s[DATA_W +: ADDR_W];
   assign din_s  = pins_s[0 +: DATA_W];

   eep_write_ctl #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .PROG_CYCLES (PROG_CYCLES)
   ) u_wctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .ce_n_s        (ce_n_s),
      .we_n_s        (we_n_s),
      .addr_s        (addr_s),
      .din_s         (din_s),
      .busy_o        (busy_o),
      .commit_o      (commit),
      .commit_addr_o (commit_addr),
      .commit_data_o (commit_data)
   );

   eep_cell_array #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .ERASED_VALUE (ERASED_VALUE)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (commit),
      .wr_addr_i (commit_addr),
      .wr_data_i (commit_data),
      .rd_addr_i (addr_s),
      .rd_data_o (rd_data)
   );

   assign drive     = ~ce_n_s & ~oe_n_s & we_n_s;
   assign dout_oe_o = drive;
   assign dout_o    = drive ? rd_data : '0;

endmodule

// File: rtl/eep_parallel_store_chk.sv
module eep_parallel_store_chk #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PROG_CYCLES = 500000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n_i,
   input logic              oe_n_i,
   input logic              we_n_i,
   input logic [DATA_W-1:0] dout_o,
   input logic              dout_oe_o,
   input logic              busy_o
);

   localparam int unsigned LEN_W = $clog2(PROG_CYCLES + 1) + 1;

   logic [LEN_W-1:0] busy_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_len_q <= '0;
      else if (busy_o) busy_len_q <= busy_len_q + 1'b1;
      else             busy_len_q <= '0;
   end

   AST_RELEASED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe_o |-> (dout_o == '0)); // R2

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!busy_o && !dout_oe_o)); // R1

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_len_q == LEN_W'(PROG_CYCLES))); // R5

   AST_BUSY_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (busy_len_q < LEN_W'(PROG_CYCLES))); // R7

   if (SYNC_STAGES == 2) begin : g_two_stage
      AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         dout_oe_o |-> (!$past(ce_n_i, 2) && !$past(oe_n_i, 2) && $past(we_n_i, 2))); // R2

      AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(busy_o) |-> ($past(ce_n_i, 3) && !$past(ce_n_i, 4) && !$past(we_n_i, 3))); // R4
   end

endmodule

bind eep_parallel_store eep_parallel_store_chk #(
   .DATA_W      (DATA_W),
   .SYNC_STAGES (SYNC_STAGES),
   .PROG_CYCLES (PROG_CYCLES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n_i    (ce_n_i),
   .oe_n_i    (oe_n_i),
   .we_n_i    (we_n_i),
   .dout_o    (dout_o),
   .dout_oe_o (dout_oe_o),
   .busy_o    (busy_o)
);

// File: tb/eep_parallel_store_tb_top.sv
`timescale 1ns/1ps
module eep_parallel_store_tb_top;

   localparam int unsigned ADDR_W = 9;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned SYNC   = 2;
   localparam int unsigned PROG   = 40;
   localparam int unsigned PIN_W  = 3 + ADDR_W + DATA_W;
   localparam int unsigned DEPTH  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [DATA_W-1:0] din_i = '0;
   logic              ce_n_i = 1'b1;
   logic              oe_n_i = 1'b1;
   logic              we_n_i = 1'b1;
   logic [DATA_W-1:0] dout_o;
   logic              dout_oe_o;
   logic              busy_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;   // 50 MHz

   eep_parallel_store #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC),
      .PROG_CYCLES (PROG)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr_i),
      .din_i     (din_i),
      .ce_n_i    (ce_n_i),
      .oe_n_i    (oe_n_i),
      .we_n_i    (we_n_i),
      .dout_o    (dout_o),
      .dout_oe_o (dout_oe_o),
      .busy_o    (busy_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [PIN_W-1:0] pipe [$];
   byte unsigned     mem_m [DEPTH];
   bit               busy_m;
   int               cnt_m;
   int               pa_m;
   byte unsigned     pd_m;
   bit               prev_ce_m;

   always @(posedge clk) begin
      if (!rst_n) begin
         busy_m    = 0;
         cnt_m     = 0;
         prev_ce_m = 1;
         pipe      = {};
         for (int i = 0; i < int'(SYNC); i++) pipe.push_back({3'b111, {(ADDR_W + DATA_W){1'b0}}});
         for (int i = 0; i < int'(DEPTH); i++) mem_m[i] = 8'hFF;
      end else begin
         logic [PIN_W-1:0] v;
         v = pipe[SYNC-1];
         if (busy_m) begin
            if (cnt_m == 0) begin
               mem_m[pa_m] = pd_m;
               busy_m = 0;
            end else cnt_m--;
         end else if (v[PIN_W-1] && !prev_ce_m && !v[PIN_W-3]) begin
            busy_m = 1;
            cnt_m  = PROG - 1;
            pa_m   = int'(v[DATA_W +: ADDR_W]);
            pd_m   = v[0 +: DATA_W];
         end
         prev_ce_m = v[PIN_W-1];
         pipe.push_front({ce_n_i, oe_n_i, we_n_i, addr_i, din_i});
         void'(pipe.pop_back());
      end
   end

   always @(negedge clk) begin
      if (rst_n && pipe.size() == SYNC) begin
         logic [PIN_W-1:0] v;
         bit               drv;
         int               exp_d;
         v     = pipe[SYNC-1];
         drv   = !v[PIN_W-1] && !v[PIN_W-2] && v[PIN_W-3];
         exp_d = drv ? int'(mem_m[int'(v[DATA_W +: ADDR_W])]) : 0;
         check(busy_o == busy_m, "R5 model busy", int'(busy_o), int'(busy_m));
         check(dout_oe_o == drv, "R2 model drive", int'(dout_oe_o), int'(drv));
         check(int'(dout_o) == exp_d, "R3 model data", int'(dout_o), exp_d);
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic do_read(input int a, input int exp, input string tag);
      @(negedge clk);
      addr_i = ADDR_W'(a); ce_n_i = 0; oe_n_i = 0; we_n_i = 1;
      repeat (2) @(negedge clk);
      check(dout_oe_o == 1'b1, tag, int'(dout_oe_o), 1);
      check(int'(dout_o) == exp, tag, int'(dout_o), exp);
      ce_n_i = 1; oe_n_i = 1;
   endtask

   task automatic do_write(input int a, input int d, input bit chk_start);
      @(negedge clk);
      ce_n_i = 1; oe_n_i = 1; we_n_i = 0; addr_i = ADDR_W'(a); din_i = DATA_W'(d);
      repeat (2) @(negedge clk);
      ce_n_i = 0;
      repeat (2) @(negedge clk);
      ce_n_i = 1;
      repeat (2) @(negedge clk);
      if (chk_start) check(busy_o == 1'b0, "R4 busy low after 2 edges", int'(busy_o), 0);
      @(negedge clk);
      if (chk_start) check(busy_o == 1'b1, "R4 busy high after 3 edges", int'(busy_o), 1);
      we_n_i = 1;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy_o && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      int n;
      repeat (5) @(negedge clk);
      check(busy_o == 0 && dout_oe_o == 0 && dout_o == 0, "R1 in reset",
            int'({busy_o, dout_oe_o, dout_o}), 0);
      rst_n = 1;
      @(negedge clk);
      check(busy_o == 0 && dout_oe_o == 0 && dout_o == 0, "R1 after reset",
            int'({busy_o, dout_oe_o, dout_o}), 0);

      do_read(0, 8'hFF, "R10 erased low");
      do_read(9'h1FF, 8'hFF, "R10 erased high");

      // Bus release cases
      @(negedge clk); ce_n_i = 0; oe_n_i = 1; we_n_i = 1;
      repeat (2) @(negedge clk);
      check(dout_oe_o == 0 && dout_o == 0, "R2 oe high", int'({dout_oe_o, dout_o}), 0);
      ce_n_i = 1; oe_n_i = 0;
      repeat (2) @(negedge clk);
      check(dout_oe_o == 0 && dout_o == 0, "R2 ce high", int'({dout_oe_o, dout_o}), 0);
      ce_n_i = 0; oe_n_i = 0; we_n_i = 0;
      repeat (2) @(negedge clk);
      check(dout_oe_o == 0 && dout_o == 0, "R2 we low", int'({dout_oe_o, dout_o}), 0);
      ce_n_i = 1; oe_n_i = 1; we_n_i = 1;
      repeat (3) @(negedge clk);
      check(busy_o == 0, "R8 simultaneous release no write", int'(busy_o), 0);

      // First write, measured interval
      do_write(0, 8'h55, 1);
      wait_idle(n);
      check(n == int'(PROG), "R5 busy length", n, PROG);
      do_read(0, 8'h55, "R3 read 55");

      // Second write, read and ignored strobe during programming
      do_write(9'h1FF, 8'hAA, 1);
      do_read(9'h1FF, 8'hFF, "R6 old value while busy");
      do_write(9'h010, 8'h33, 0);
      check(busy_o == 1, "R7 still in first interval", int'(busy_o), 1);
      wait_idle(n);
      repeat (6) @(negedge clk);
      check(busy_o == 0, "R7 no second interval", int'(busy_o), 0);
      do_read(9'h010, 8'hFF, "R7 ignored location");
      do_read(9'h1FF, 8'hAA, "R9 top address");
      do_read(0, 8'h55, "R9 bottom kept");

      // Strobe with write request high
      @(negedge clk); addr_i = 9'h020; din_i = 8'h77; ce_n_i = 0; oe_n_i = 1; we_n_i = 1;
      repeat (2) @(negedge clk);
      ce_n_i = 1;
      repeat (5) @(negedge clk);
      check(busy_o == 0, "R8 no programming", int'(busy_o), 0);
      do_read(9'h020, 8'hFF, "R8 location unchanged");

      do_write(9'h020, 8'h00, 1);
      wait_idle(n);
      do_read(9'h020, 8'h00, "R3 read 00");
      do_read(9'h1FF, 8'hAA, "R9 top after other write");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule